// File: doc/BRIEF.md
# Rotated Immediate Codec

This block converts between a 32-bit constant and a compact 12-bit immediate field. The field holds an 8-bit base and a 4-bit rotation selector. The constant the field stands for is the base, zero-extended to 32 bits and rotated right by twice the selector. Such a field can reach many useful constants, but it cannot reach every 32-bit value.

The decode path is purely combinational. An instruction decoder feeds it the field and uses the expanded constant in the same cycle.

The encode path runs a search over several cycles. A one-cycle start pulse captures a constant. The searcher then tests one rotation selector per clock, starting at 0 and counting upward. It stops at the first selector that works. If all 16 selectors fail, it stops and flags the constant as unrepresentable. An assembler-side or code-generation helper uses the encode path to decide whether a literal fits the compact form.

Top module: `rotimm_codec`

## Requirements
- R1: `dec_value_o` equals `{24'b0, dec_field_i[7:0]}` rotated right by `2*dec_field_i[11:8]` bit positions. Bits [11:8] hold the rotation selector and bits [7:0] hold the base. The output changes in the same cycle as the input.
- R2: The encoder tries selectors 0, 1, 2 … 15 in that order, one per clock. When several encodings exist, it reports the one with the smallest selector.
- R3: A selector r matches when rotating the captured constant left by 2r leaves bits [31:8] all zero. On a match, `enc_field_o` is `{r, low byte of that rotated value}`, and decoding that field gives back the captured constant.
- R4: If no selector from 0 to 15 matches, the encoder raises `enc_unrep_o`, keeps `enc_ok_o` low and drives `enc_field_o` to zero. `enc_ok_o` and `enc_unrep_o` are never high together.
- R5: The start pulse is sampled on a clock edge. For a match at selector r, `enc_done_o` goes high for exactly one cycle, r+1 edges after that start edge. For an unrepresentable constant, it goes high 16 edges after the start edge.
- R6: `enc_busy_o` is high from the edge that accepts a start until the edge that raises `enc_done_o`. A start pulse while busy is ignored: the search in progress keeps its captured constant and its result.
- R7: The constant zero encodes as field 0x000 with `enc_ok_o` high, one edge after the start edge.
- R8: `enc_field_o`, `enc_ok_o` and `enc_unrep_o` keep the last result until the next accepted start, which clears `enc_ok_o` and `enc_unrep_o`.
- R9: While `rst_ni` is low, `enc_busy_o`, `enc_done_o`, `enc_ok_o` and `enc_unrep_o` are 0 and `enc_field_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dec_field_i | input | 12 | Immediate field to expand |
| dec_value_o | output | 32 | Expanded constant |
| enc_start_i | input | 1 | Start pulse; captures `enc_value_i` when idle |
| enc_value_i | input | 32 | Constant to encode |
| enc_busy_o | output | 1 | Search in progress |
| enc_done_o | output | 1 | One-cycle pulse when a search ends |
| enc_ok_o | output | 1 | The last search found an encoding |
| enc_unrep_o | output | 1 | The last search found no encoding |
| enc_field_o | output | 12 | Encoding found by the last search |

## Verification
Suppose the selector counter skips a value or restarts. Then a constant whose only encoding sits at the skipped selector is either reported unrepresentable, or reported with a larger selector. The done pulse also lands on a cycle other than r+1, so timing every done pulse against its start catches the fault within one search. Suppose instead the captured constant were overwritten by a start pulse that arrives mid-search. The result would then decode to the wrong value, and the bench sees this as soon as that search completes. A wrong decode rotation shows at once on `dec_value_o`, because that path has no register.

// File: rtl/rotimm_pkg.sv
package rotimm_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned BASE_W  = 8;
  localparam int unsigned ROT_W   = 4;
  localparam int unsigned FIELD_W = ROT_W + BASE_W;
  localparam int unsigned SHAMT_W = $clog2(DATA_W);

  function automatic logic [DATA_W-1:0] rot_right(logic [DATA_W-1:0] x, logic [SHAMT_W-1:0] n);
    logic [2*DATA_W-1:0] t;
    t = {x, x} >> n;
    return t[DATA_W-1:0];
  endfunction

  function automatic logic [DATA_W-1:0] rot_left(logic [DATA_W-1:0] x, logic [SHAMT_W-1:0] n);
    logic [2*DATA_W-1:0] t;
    t = {x, x} << n;
    return t[2*DATA_W-1:DATA_W];
  endfunction

  // selector -> rotate amount (selector doubled)
  function automatic logic [SHAMT_W-1:0] sel_to_amt(logic [ROT_W-1:0] sel);
    return SHAMT_W'({sel, 1'b0});
  endfunction
endpackage

// File: rtl/rotimm_expand.sv
module rotimm_expand
  import rotimm_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned BW = BASE_W,
  parameter int unsigned RW = ROT_W,
  localparam int unsigned FW = RW + BW
) (
  input  logic [FW-1:0] field_i,
  output logic [DW-1:0] value_o
);
  logic [BW-1:0] base;
  logic [RW-1:0] sel;
  logic [DW-1:0] base_ext;

  assign base     = field_i[BW-1:0];
  assign sel      = field_i[FW-1:BW];
  assign base_ext = DW'(base);
  assign value_o  = rot_right(base_ext, sel_to_amt(sel));

  // R1: undoing the rotation must leave only the base
  always_comb begin
    p_expand_inverse_r1: assert (rot_left(value_o, sel_to_amt(sel)) == base_ext);
  end
endmodule

// File: rtl/rotimm_probe.sv
module rotimm_probe
  import rotimm_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned BW = BASE_W,
  parameter int unsigned RW = ROT_W,
  localparam int unsigned NSEL = 1 << RW
) (
  input  logic [DW-1:0] value_i,
  input  logic [RW-1:0] sel_i,
  output logic          hit_o,
  output logic [BW-1:0] base_o
);
  logic [DW-1:0] cand [NSEL];
  logic [DW-1:0] picked;

  // fixed-amount rotations, one per selector; muxed by sel_i
  for (genvar g = 0; g < NSEL; g++) begin : g_cand
    assign cand[g] = rot_left(value_i, sel_to_amt(RW'(g)));
  end

  assign picked = cand[sel_i];
  assign hit_o  = ~|picked[DW-1:BW];
  assign base_o = picked[BW-1:0];
endmodule

// File: rtl/rotimm_search.sv
module rotimm_search
  import rotimm_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned BW = BASE_W,
  parameter int unsigned RW = ROT_W,
  localparam int unsigned FW = RW + BW,
  localparam logic [RW-1:0] SEL_LAST = {RW{1'b1}}
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] value_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          ok_o,
  output logic          unrep_o,
  output logic [FW-1:0] field_o
);
  logic          busy_q, done_q, ok_q, unrep_q;
  logic [RW-1:0] sel_q;
  logic [DW-1:0] val_q;
  logic [FW-1:0] field_q;
  logic          hit;
  logic [BW-1:0] hit_base;

  rotimm_probe #(.DW(DW), .BW(BW), .RW(RW)) u_probe (
    .value_i (val_q),
    .sel_i   (sel_q),
    .hit_o   (hit),
    .base_o  (hit_base)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      ok_q    <= 1'b0;
      unrep_q <= 1'b0;
      sel_q   <= '0;
      val_q   <= '0;
      field_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q  <= 1'b1;
          sel_q   <= '0;
          val_q   <= value_i;
          ok_q    <= 1'b0;
          unrep_q <= 1'b0;
        end
      end else if (hit) begin
        busy_q  <= 1'b0;
        done_q  <= 1'b1;
        ok_q    <= 1'b1;
        field_q <= {sel_q, hit_base};
      end else if (sel_q == SEL_LAST) begin
        busy_q  <= 1'b0;
        done_q  <= 1'b1;
        unrep_q <= 1'b1;
        field_q <= '0;
      end else begin
        sel_q <= sel_q + 1'b1;
      end
    end
  end

  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign ok_o    = ok_q;
  assign unrep_o = unrep_q;
  assign field_o = field_q;

  p_scan_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !hit && sel_q != SEL_LAST) |=> (busy_q && sel_q == $past(sel_q) + 1'b1));

  p_roundtrip_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && ok_q) |->
      rot_right(DW'(field_q[BW-1:0]), sel_to_amt(field_q[FW-1:BW])) == val_q);

  p_flags_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ok_q && unrep_q));

  p_unrep_at_end_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unrep_q) |-> $past(sel_q) == SEL_LAST);

  p_done_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  p_ignore_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i) |=> $stable(val_q));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !start_i) |=> ($stable(field_q) && $stable(ok_q) && $stable(unrep_q)));
endmodule

// File: rtl/rotimm_codec.sv
module rotimm_codec
  import rotimm_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned BW = BASE_W,
  parameter int unsigned RW = ROT_W,
  localparam int unsigned FW = RW + BW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [FW-1:0] dec_field_i,
  output logic [DW-1:0] dec_value_o,
  input  logic          enc_start_i,
  input  logic [DW-1:0] enc_value_i,
  output logic          enc_busy_o,
  output logic          enc_done_o,
  output logic          enc_ok_o,
  output logic          enc_unrep_o,
  output logic [FW-1:0] enc_field_o
);
  rotimm_expand #(.DW(DW), .BW(BW), .RW(RW)) u_expand (
    .field_i (dec_field_i),
    .value_o (dec_value_o)
  );

  rotimm_search #(.DW(DW), .BW(BW), .RW(RW)) u_search (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (enc_start_i),
    .value_i (enc_value_i),
    .busy_o  (enc_busy_o),
    .done_o  (enc_done_o),
    .ok_o    (enc_ok_o),
    .unrep_o (enc_unrep_o),
    .field_o (enc_field_o)
  );

  p_idle_no_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_done_o |-> !enc_busy_o);
endmodule

// File: tb/tb_rotimm_codec.sv
`timescale 1ns/1ps
module tb_rotimm_codec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] dec_field = '0;
  logic [31:0] dec_value;
  logic        enc_start = 1'b0;
  logic [31:0] enc_value = '0;
  logic        enc_busy, enc_done, enc_ok, enc_unrep;
  logic [11:0] enc_field;

  always #10 clk = ~clk;

  rotimm_codec dut (
    .clk_i(clk), .rst_ni(rst_n),
    .dec_field_i(dec_field), .dec_value_o(dec_value),
    .enc_start_i(enc_start), .enc_value_i(enc_value),
    .enc_busy_o(enc_busy), .enc_done_o(enc_done), .enc_ok_o(enc_ok),
    .enc_unrep_o(enc_unrep), .enc_field_o(enc_field)
  );

  typedef struct {
    logic [31:0] val;
    logic [11:0] field;
    logic        ok;
    int          t0;
    int          lat;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;
  logic [11:0] last_field;
  logic        last_ok;
  logic [31:0] seed = 32'h1234_5678;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] m_ror(logic [31:0] x, int n);
    logic [31:0] o;
    for (int i = 0; i < 32; i++) o[i] = x[(i + n) % 32];
    return o;
  endfunction

  function automatic logic [31:0] m_rol(logic [31:0] x, int n);
    logic [31:0] o;
    for (int i = 0; i < 32; i++) o[(i + n) % 32] = x[i];
    return o;
  endfunction

  function automatic logic [31:0] m_dec(logic [11:0] f);
    return m_ror({24'b0, f[7:0]}, 2 * int'(f[11:8]));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic next_rand();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
  endtask

  // builds expected result; lowest selector first (R2, R3, R4)
  function automatic item_t model_enc(logic [31:0] v);
    item_t it;
    logic [31:0] t;
    it.val = v; it.field = '0; it.ok = 1'b0; it.lat = 17; it.t0 = 0;
    for (int r = 15; r >= 0; r--) begin
      t = m_rol(v, 2 * r);
      if (t[31:8] == 24'b0) begin
        it.field = {4'(r), t[7:0]};
        it.ok = 1'b1;
        it.lat = r + 2;
      end
    end
    return it;
  endfunction

  // driver: one start pulse, expectation into the scoreboard
  task automatic drive_enc(input logic [31:0] v, input bit poke_busy);
    item_t it;
    it = model_enc(v);
    @(negedge clk);
    it.t0 = cyc;
    q.push_back(it);
    enc_value = v;
    enc_start = 1'b1;
    @(negedge clk);
    enc_start = 1'b0;
    enc_value = ~v;
    if (poke_busy && it.lat > 3) begin
      chk("R6 busy after start", 32'(enc_busy), 32'd1);
      enc_value = 32'hDEAD_BEEF;
      enc_start = 1'b1;  // must be ignored
      @(negedge clk);
      enc_start = 1'b0;
    end
    while (q.size() != 0) @(negedge clk);
    last_field = it.field;
    last_ok = it.ok;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && enc_done) begin
      if (q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R5 unexpected done actual=1 expected=0");
      end else begin
        item_t it;
        it = q.pop_front();
        chk("R3 field", 32'(enc_field), 32'(it.field));
        chk("R4 ok flag", 32'(enc_ok), 32'(it.ok));
        chk("R4 unrep flag", 32'(enc_unrep), 32'(!it.ok));
        chk("R5 latency", 32'(cyc - it.t0), 32'(it.lat));
        chk("R6 busy low at done", 32'(enc_busy), 32'd0);
        if (it.ok) chk("R3 roundtrip", m_dec(enc_field), it.val);
      end
    end
  end

  initial begin
    int guard = 0;
    while (guard < 100000) begin
      @(posedge clk);
      guard++;
    end
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [11:0] f;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 busy", 32'(enc_busy), 32'd0);
    chk("R9 done", 32'(enc_done), 32'd0);
    chk("R9 ok", 32'(enc_ok), 32'd0);
    chk("R9 unrep", 32'(enc_unrep), 32'd0);
    chk("R9 field", 32'(enc_field), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 decode
    dec_field = 12'h0FF; #1 chk("R1 dec", dec_value, 32'h0000_00FF);
    dec_field = 12'h4FF; #1 chk("R1 dec", dec_value, 32'hFF00_0000);
    dec_field = 12'hF01; #1 chk("R1 dec", dec_value, 32'h0000_0004);
    dec_field = 12'h1AB; #1 chk("R1 dec", dec_value, 32'hC000_002A);
    for (int i = 0; i < 40; i++) begin
      next_rand();
      dec_field = seed[11:0];
      #1 chk("R1 dec rand", dec_value, m_dec(seed[11:0]));
    end

    // R7 zero
    drive_enc(32'h0, 1'b0);
    // R2 lowest selector wins
    drive_enc(32'h0000_0004, 1'b0);
    drive_enc(32'h0000_0400, 1'b0);
    drive_enc(32'h0000_00FF, 1'b0);
    drive_enc(32'hFF00_0000, 1'b0);
    drive_enc(32'hF000_000F, 1'b0);
    drive_enc(32'h0000_03FC, 1'b0);   // only selector 15
    // R4 unrepresentable
    drive_enc(32'h0000_0101, 1'b0);
    drive_enc(32'hFFFF_FFFF, 1'b0);
    // R6 start while busy ignored
    drive_enc(32'h0003_FC00, 1'b1);
    drive_enc(32'h1234_5678, 1'b1);

    // R8 hold while idle
    repeat (5) @(negedge clk);
    chk("R8 field hold", 32'(enc_field), 32'(last_field));
    chk("R8 ok hold", 32'(enc_unrep), 32'(!last_ok));

    for (int i = 0; i < 20; i++) begin
      next_rand();
      f = seed[11:0];
      drive_enc(m_dec(f), 1'b0);   // representable, R3
      next_rand();
      drive_enc(seed, 1'b0);
    end

    repeat (3) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule